// File: doc/BRIEF.md
# Receive FIFO with Threshold and Idle-Line Flags

This block sits behind an asynchronous serial deserializer and holds received bytes in a 16-entry FIFO until a bus master pops them. It raises two interrupt sources. The level flag asserts whenever the FIFO holds at least a programmable trigger count of bytes. The idle flag asserts once the line has been quiet for 15 bit times after the last stop bit while the FIFO holds fewer bytes than the trigger count. The 15 bit times are one and a half frames of 8 data bits, 1 stop bit and no parity. The idle flag exists so that a short tail of bytes below the trigger count still produces an interrupt.

The idle flag is armed only in asynchronous mode with the FIFO enabled. Pending framing or parity error flags block it. To clear it, software reads the flag while it is 1 and then writes 0. The write takes effect only when the FIFO has been drained. Because of this rule, a byte that arrives while software is servicing the flag keeps the flag up, so the byte cannot be left stranded. A 0-to-1 transition of the FIFO enable also clears the flag. The trigger count is a configuration input; the configuration register outside this block resets it to 15.

Top module: `rx_fifo_idle_flags`

## Requirements
- R1: `rdf_o` is 1 exactly when `fill_o` is greater than or equal to `trig_i`.
- R2: Bytes leave in arrival order. `fill_o` counts the stored bytes, up to a maximum of 16. A push when the FIFO is full is dropped, and a pop when it is empty has no effect. With neither a push nor a pop, `fill_o` holds.
- R3: Suppose `rx_valid_i` pulses, then 15 `bit_tick_i` pulses arrive with `rx_busy_i` low, the FIFO non-empty and `fill_o < trig_i`. Then `dr_o` rises on the clock edge after the 15th tick. After 14 ticks it is still 0.
- R4: `dr_o` does not set while `fill_o >= trig_i`.
- R5: `dr_o` does not set while `fer_o` or `per_o` is 1.
- R6: `dr_o` never sets when `fifo_en_i` is 0 or `async_i` is 0.
- R7: A `stat_rd_i` pulse that sees `dr_o`=1 arms a clear. The next `stat_wr_i` with `wr_dr_i`=0 clears `dr_o`, but only if `fill_o` is 0 at that write. Any `stat_wr_i` disarms. A write of 0 that is not armed, or that comes while the FIFO is non-empty, leaves `dr_o` at 1.
- R8: A 0-to-1 transition of `fifo_en_i` clears `dr_o`.
- R9: Each `rx_valid_i` restarts the idle count. The count holds while `rx_busy_i` is 1 and stays at zero while the FIFO is empty. The idle flag fires once per idle period: after a clear through R8 it stays 0 until a new byte arrives, and after that byte it can fire again.
- R10: `irq_o` is `(rdf_o & rdf_ie_i) | (dr_o & dr_ie_i)`.
- R11: A byte pushed with `rx_fer_i` or `rx_per_i` set makes `fer_o` or `per_o` 1. These flags stay set until a `stat_wr_i` with `wr_fer_i` or `wr_per_i` at 0 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Deserializer delivers a byte (stop bit seen) |
| rx_data_i | input | 8 | Received byte |
| rx_fer_i | input | 1 | Framing error on this byte |
| rx_per_i | input | 1 | Parity error on this byte |
| rx_busy_i | input | 1 | A frame is in progress on the line |
| bit_tick_i | input | 1 | One pulse per bit time |
| pop_i | input | 1 | Bus read of the data register, pops the FIFO |
| rd_data_o | output | 8 | Head of FIFO |
| fill_o | output | 5 | Number of stored bytes |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| wr_dr_i | input | 1 | Write value for the idle flag |
| wr_fer_i | input | 1 | Write value for the framing error flag |
| wr_per_i | input | 1 | Write value for the parity error flag |
| fifo_en_i | input | 1 | FIFO mode enable |
| async_i | input | 1 | Asynchronous mode |
| trig_i | input | 5 | Receive trigger count |
| rdf_ie_i | input | 1 | Level interrupt enable |
| dr_ie_i | input | 1 | Idle interrupt enable |
| rdf_o | output | 1 | Level flag |
| dr_o | output | 1 | Idle data-ready flag |
| fer_o | output | 1 | Sticky framing error |
| per_o | output | 1 | Sticky parity error |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checker watches every cycle for four things. The fill count never exceeds the depth and holds when there is no traffic. Each rise of the idle flag was preceded by a below-trigger level, clear error flags and an asynchronous FIFO mode. Each fall of the idle flag follows either an empty FIFO at a status write or a FIFO-enable rising edge. The interrupt never asserts without a flag behind it. Other properties need a sequence of stimulus and only the bench scenarios show them: the exact tick on which the idle flag rises, the read-then-write handshake and its refusal while bytes remain, the fire-once behaviour across an enable toggle, and the rearm after a late byte.

// File: rtl/rx_fifo_idle_pkg.sv
package rx_fifo_idle_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = 10;                  // start + 8 data + stop
  localparam int unsigned IDLE_BITS  = (FRAME_BITS * 3) / 2; // 1.5 frames
endpackage

// File: rtl/rx_fifo_idle_queue.sv
module rx_fifo_idle_queue #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              push_ok_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CNT_W'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= data_i;
  end

  assign data_o    = mem_q[rptr_q];
  assign count_o   = cnt_q;
  assign push_ok_o = push_ok;
endmodule

// File: rtl/rx_fifo_idle_timer.sv
module rx_fifo_idle_timer #(
  parameter int unsigned IDLE_BITS = 15,
  localparam int unsigned T_W = $clog2(IDLE_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,    // byte completed
  input  logic busy_i,
  input  logic tick_i,
  input  logic empty_i,
  input  logic fire_i,    // flag actually set this cycle
  output logic expire_o
);
  logic [T_W-1:0] cnt_q;
  logic           fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (stop_i || empty_i)
        cnt_q <= '0;
      else if (tick_i && !busy_i && cnt_q != T_W'(IDLE_BITS))
        cnt_q <= cnt_q + 1'b1;

      if (stop_i)      fired_q <= 1'b0;
      else if (fire_i) fired_q <= 1'b1;
    end
  end

  assign expire_o = (cnt_q == T_W'(IDLE_BITS)) && !fired_q && !empty_i && !busy_i;
endmodule

// File: rtl/rx_fifo_idle_status.sv
module rx_fifo_idle_status #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] trig_i,
  input  logic             fifo_en_i,
  input  logic             async_i,
  input  logic             err_fer_i,   // accepted byte flagged
  input  logic             err_per_i,
  input  logic             stat_rd_i,
  input  logic             stat_wr_i,
  input  logic             wr_dr_i,
  input  logic             wr_fer_i,
  input  logic             wr_per_i,
  output logic             dr_set_o,
  output logic             rdf_o,
  output logic             dr_o,
  output logic             fer_o,
  output logic             per_o
);
  logic dr_q, fer_q, per_q, armed_q, fen_q;
  logic below, fen_rise, dr_clr;

  assign below    = count_i < trig_i;
  assign fen_rise = fifo_en_i && !fen_q;
  assign dr_set_o = expire_i && below && !fer_q && !per_q && fifo_en_i && async_i;
  assign dr_clr   = (stat_wr_i && !wr_dr_i && armed_q && count_i == '0) || fen_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q    <= 1'b0;
      fer_q   <= 1'b0;
      per_q   <= 1'b0;
      armed_q <= 1'b0;
      fen_q   <= 1'b0;
    end else begin
      fen_q <= fifo_en_i;
      if (dr_clr)        dr_q <= 1'b0;
      else if (dr_set_o) dr_q <= 1'b1;

      if (stat_wr_i)      armed_q <= 1'b0;
      else if (stat_rd_i) armed_q <= dr_q;

      if (err_fer_i)                  fer_q <= 1'b1;
      else if (stat_wr_i && !wr_fer_i) fer_q <= 1'b0;
      if (err_per_i)                  per_q <= 1'b1;
      else if (stat_wr_i && !wr_per_i) per_q <= 1'b0;
    end
  end

  assign rdf_o = !below;
  assign dr_o  = dr_q;
  assign fer_o = fer_q;
  assign per_o = per_q;
endmodule

// File: rtl/rx_fifo_idle_flags.sv
module rx_fifo_idle_flags
  import rx_fifo_idle_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_fer_i,
  input  logic              rx_per_i,
  input  logic              rx_busy_i,
  input  logic              bit_tick_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  fill_o,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic              wr_dr_i,
  input  logic              wr_fer_i,
  input  logic              wr_per_i,
  input  logic              fifo_en_i,
  input  logic              async_i,
  input  logic [CNT_W-1:0]  trig_i,
  input  logic              rdf_ie_i,
  input  logic              dr_ie_i,
  output logic              rdf_o,
  output logic              dr_o,
  output logic              fer_o,
  output logic              per_o,
  output logic              irq_o
);
  logic             push_ok, expire, dr_set;
  logic [CNT_W-1:0] count;

  rx_fifo_idle_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
    .clk_i, .rst_ni,
    .push_i   (rx_valid_i),
    .data_i   (rx_data_i),
    .pop_i    (pop_i),
    .data_o   (rd_data_o),
    .count_o  (count),
    .push_ok_o(push_ok)
  );

  rx_fifo_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
    .clk_i, .rst_ni,
    .stop_i  (rx_valid_i),
    .busy_i  (rx_busy_i),
    .tick_i  (bit_tick_i),
    .empty_i (count == '0),
    .fire_i  (dr_set),
    .expire_o(expire)
  );

  rx_fifo_idle_status #(.CNT_W(CNT_W)) u_status (
    .clk_i, .rst_ni,
    .expire_i (expire),
    .count_i  (count),
    .trig_i   (trig_i),
    .fifo_en_i(fifo_en_i),
    .async_i  (async_i),
    .err_fer_i(push_ok && rx_fer_i),
    .err_per_i(push_ok && rx_per_i),
    .stat_rd_i(stat_rd_i),
    .stat_wr_i(stat_wr_i),
    .wr_dr_i  (wr_dr_i),
    .wr_fer_i (wr_fer_i),
    .wr_per_i (wr_per_i),
    .dr_set_o (dr_set),
    .rdf_o    (rdf_o),
    .dr_o     (dr_o),
    .fer_o    (fer_o),
    .per_o    (per_o)
  );

  assign fill_o = count;
  assign irq_o  = (rdf_o && rdf_ie_i) || (dr_o && dr_ie_i);
endmodule

// File: rtl/rx_fifo_idle_flags_chk.sv
module rx_fifo_idle_flags_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_valid_i,
  input logic             pop_i,
  input logic             stat_wr_i,
  input logic             fifo_en_i,
  input logic             async_i,
  input logic [CNT_W-1:0] trig_i,
  input logic [CNT_W-1:0] fill_o,
  input logic             rdf_o,
  input logic             dr_o,
  input logic             fer_o,
  input logic             per_o,
  input logic             irq_o
);
  logic fen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fen_q <= 1'b0;
    else         fen_q <= fifo_en_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= CNT_W'(DEPTH)); // R2
  AST_FILL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid_i && !pop_i) |=> $stable(fill_o)); // R2
  AST_DR_BELOW_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dr_o) |-> $past(fill_o < trig_i)); // R4
  AST_DR_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dr_o) |-> $past(!fer_o && !per_o)); // R5
  AST_DR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dr_o) |-> $past(fifo_en_i && async_i)); // R6
  AST_DR_CLEAR_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dr_o) |-> $past((stat_wr_i && fill_o == '0) || (fifo_en_i && !fen_q))); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdf_o || dr_o)); // R10
endmodule

bind rx_fifo_idle_flags rx_fifo_idle_flags_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .pop_i(pop_i),
  .stat_wr_i(stat_wr_i), .fifo_en_i(fifo_en_i), .async_i(async_i),
  .trig_i(trig_i), .fill_o(fill_o), .rdf_o(rdf_o), .dr_o(dr_o),
  .fer_o(fer_o), .per_o(per_o), .irq_o(irq_o)
);

// File: tb/rx_fifo_idle_flags_tb_top.sv
module rx_fifo_idle_flags_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 0, rx_fer_i = 0, rx_per_i = 0, rx_busy_i = 0, bit_tick_i = 0;
  logic [7:0] rx_data_i = '0;
  logic       pop_i = 0, stat_rd_i = 0, stat_wr_i = 0;
  logic       wr_dr_i = 1, wr_fer_i = 1, wr_per_i = 1;
  logic       fifo_en_i = 1, async_i = 1, rdf_ie_i = 0, dr_ie_i = 0;
  logic [4:0] trig_i = 5'd15;
  logic [7:0] rd_data_o;
  logic [4:0] fill_o;
  logic       rdf_o, dr_o, fer_o, per_o, irq_o;
  int         n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rx_fifo_idle_flags dut_i (.*);

  // trig[10:6], bytes[5:1], expected rdf[0]
  localparam logic [10:0] VEC [7] = '{
    {5'd15, 5'd14, 1'b0}, {5'd15, 5'd15, 1'b1}, {5'd15, 5'd16, 1'b1},
    {5'd1,  5'd0,  1'b0}, {5'd1,  5'd1,  1'b1}, {5'd4,  5'd3,  1'b0},
    {5'd4,  5'd5,  1'b1}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] d, input logic fe = 0, input logic pe = 0);
    @(negedge clk_i);
    rx_valid_i = 1; rx_data_i = d; rx_fer_i = fe; rx_per_i = pe;
    @(negedge clk_i);
    rx_valid_i = 0; rx_fer_i = 0; rx_per_i = 0;
  endtask

  task automatic pop_chk(input string req, input int exp);
    @(negedge clk_i);
    chk(req, rd_data_o, exp);
    pop_i = 1;
    @(negedge clk_i);
    pop_i = 0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); pop_i = 1;
      @(negedge clk_i); pop_i = 0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); bit_tick_i = 1;
      @(negedge clk_i); bit_tick_i = 0;
    end
  endtask

  task automatic srd();
    @(negedge clk_i); stat_rd_i = 1;
    @(negedge clk_i); stat_rd_i = 0;
  endtask

  task automatic swr(input logic d, input logic f = 1, input logic p = 1);
    @(negedge clk_i); stat_wr_i = 1; wr_dr_i = d; wr_fer_i = f; wr_per_i = p;
    @(negedge clk_i); stat_wr_i = 0; wr_dr_i = 1; wr_fer_i = 1; wr_per_i = 1;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    trig_i = 5'd15; fifo_en_i = 1; async_i = 1; rdf_ie_i = 0; dr_ie_i = 0;
    idle(2); rst_ni = 1; idle(1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3); rst_ni = 1; idle(1);
    // reset state
    chk("R2 reset fill", fill_o, 0);
    chk("R1 reset rdf", rdf_o, 0);
    chk("R3 reset dr", dr_o, 0);
    chk("R10 reset irq", irq_o, 0);

    // R1 / R10 level table
    foreach (VEC[k]) begin
      do_reset();
      trig_i = VEC[k][10:6]; rdf_ie_i = 1;
      for (int b = 0; b < int'(VEC[k][5:1]); b++) push(8'(b));
      idle(1);
      chk("R1 rdf level", rdf_o, VEC[k][0]);
      chk("R10 irq level", irq_o, VEC[k][0]);
      chk("R2 fill", fill_o, VEC[k][5:1]);
    end
    rdf_ie_i = 0; idle(1);
    chk("R10 irq masked", irq_o, 0);

    // R2 order, overflow drop, empty pop
    do_reset();
    for (int b = 0; b < 18; b++) push(8'(8'h40 + b));
    chk("R2 full fill", fill_o, 16);
    for (int b = 0; b < 16; b++) pop_chk("R2 order", 8'h40 + b);
    pop_n(1);
    chk("R2 empty pop", fill_o, 0);

    // R3 timeout edge
    do_reset(); dr_ie_i = 1;
    push(8'h11); push(8'h22); push(8'h33);
    ticks(14); idle(2);
    chk("R3 at 14 ticks", dr_o, 0);
    ticks(1); idle(1);
    chk("R3 at 15 ticks", dr_o, 1);
    chk("R10 irq dr", irq_o, 1);

    // R7 clear handshake
    swr(0); idle(1);
    chk("R7 write w/o read", dr_o, 1);
    srd(); swr(0); idle(1);
    chk("R7 write non-empty", dr_o, 1);
    pop_n(3); swr(0); idle(1);
    chk("R7 disarmed write", dr_o, 1);
    srd(); swr(0); idle(1);
    chk("R7 read then write empty", dr_o, 0);

    // R9 busy hold, rearm
    push(8'h55);
    rx_busy_i = 1; ticks(20); rx_busy_i = 0; idle(1);
    chk("R9 busy holds", dr_o, 0);
    ticks(15); idle(1);
    chk("R9 rearm after byte", dr_o, 1);
    // R8 enable rising clears; R9 no refire
    @(negedge clk_i); fifo_en_i = 0;
    @(negedge clk_i); fifo_en_i = 1;
    idle(1);
    chk("R8 enable rise clears", dr_o, 0);
    ticks(20); idle(1);
    chk("R9 fires once", dr_o, 0);
    push(8'h66); ticks(15); idle(1);
    chk("R9 late byte rearms", dr_o, 1);

    // R4 at or above trigger
    do_reset(); trig_i = 5'd2;
    push(1); push(2); push(3);
    ticks(20); idle(1);
    chk("R4 above trig", dr_o, 0);
    chk("R1 above trig", rdf_o, 1);

    // R5 / R11 error flags
    do_reset();
    push(8'h01, 1, 0);
    ticks(20); idle(1);
    chk("R11 fer set", fer_o, 1);
    chk("R5 fer blocks", dr_o, 0);
    do_reset();
    push(8'h02, 0, 1);
    ticks(20); idle(1);
    chk("R11 per set", per_o, 1);
    chk("R5 per blocks", dr_o, 0);
    swr(1, 1, 0); idle(1);
    chk("R11 per cleared", per_o, 0);
    do_reset();
    push(8'h03, 1, 0);
    swr(1, 0, 1); idle(1);
    chk("R11 fer cleared", fer_o, 0);

    // R6 mode gating
    do_reset(); async_i = 0;
    push(8'h04); ticks(20); idle(1);
    chk("R6 sync mode", dr_o, 0);
    do_reset(); fifo_en_i = 0;
    push(8'h05); ticks(20); idle(1);
    chk("R6 fifo off", dr_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule